// File: doc/BRIEF.md
# Transmit Ring Halt Controller

This block keeps the halt state of several transmit descriptor rings in a DMA-driven network transmitter. It watches the results of descriptor fetches and the responses of the bus that carries descriptor and data reads. It also gives each ring a DMA-enable line, and it gives the scheduler a per-ring halted indication.

A fetch that finds no ready descriptor halts only the ring it came from. Some conditions count as general transmit errors: a bad address, an uncorrectable read error, or a descriptor marked ready whose length is zero. Any general error halts every ring, whatever its queue-enable says. It also sends a one-cycle event to the interrupt logic.

Software reads the halt bits and releases a ring by writing a one to its bit position. A graceful-stop request pauses all DMA but never sets a halt bit. The reset is asynchronous and active low. It is expected to be released synchronously by the reset synchroniser that drives it.

Top module: `tx_ring_halt_ctrl`

## Requirements
- R1: While reset is asserted and right after it, every halt bit is 0, txe_o is 0, and dma_en_o equals q_en_i bit for bit.
- R2: For each ring i, dma_en_o[i] = q_en_i[i] AND NOT halt_stat_o[i] AND NOT gstop_i. any_halted_o is the OR of all halt bits. A ring whose queue-enable is low and whose halt bit is clear reports 0 in halt_stat_o.
- R3: In a cycle with wr_en_i high, each bit of wr_data_i that is 1 clears the halt bit at the same position on the next clock edge. Each bit that is 0 leaves that halt bit unchanged.
- R4: A fetch result with fetch_vld_i=1 and fetch_empty_i=1 sets the halt bit of ring fetch_ring_i on the next edge and changes no other bit. In that case fetch_ready_i and fetch_len_i are ignored.
- R5: A fetch result with fetch_vld_i=1, fetch_empty_i=0, fetch_ready_i=1 and fetch_len_i=0 is a general error. It sets every halt bit on the next edge, whatever q_en_i holds.
- R6: A bus response with rsp_vld_i=1 and either rsp_addr_err_i=1 or rsp_ecc_err_i=1 is a general error that sets every halt bit on the next edge. Error flags without rsp_vld_i have no effect.
- R7: gstop_i never sets a halt bit, however long it stays high.
- R8: txe_o is high in exactly the cycle after each cycle that holds a general error, and low otherwise.
- R9: If a set condition and a write-one-to-clear hit the same bit in the same cycle, the bit ends up set.
- R10: A valid fetch with a ready descriptor of nonzero length, or with fetch_ready_i=0, changes no halt bit and raises no txe_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_en_i | input | NUM_RINGS | Per-ring queue enable |
| gstop_i | input | 1 | Graceful-stop request, pauses all DMA |
| fetch_vld_i | input | 1 | Descriptor fetch result valid |
| fetch_ring_i | input | RING_W | Ring the fetch result belongs to |
| fetch_empty_i | input | 1 | No ready descriptor could be fetched |
| fetch_ready_i | input | 1 | Ready flag of the fetched descriptor |
| fetch_len_i | input | LEN_W | Length field of the fetched descriptor |
| rsp_vld_i | input | 1 | Bus response valid |
| rsp_addr_err_i | input | 1 | Invalid descriptor or data address |
| rsp_ecc_err_i | input | 1 | Uncorrectable read error |
| wr_en_i | input | 1 | Software write to the halt status |
| wr_data_i | input | NUM_RINGS | Write-one-to-clear mask |
| halt_stat_o | output | NUM_RINGS | Halt status bits |
| dma_en_o | output | NUM_RINGS | Per-ring DMA enable |
| any_halted_o | output | 1 | At least one ring is halted |
| txe_o | output | 1 | One-cycle general transmit error event |

## Verification
The bench builds the block with NUM_RINGS=3 and LEN_W=4. With these values every clear mask can be tried against every set of halt bits, and every queue-enable pattern can be compared with the DMA-enable outputs. Every descriptor length can be tried with the ready flag both high and low. The small ring count also keeps the tests of a single ring's empty fetch and of the collisions between setting and clearing short enough to repeat on each ring.

// File: rtl/txh_pkg.sv
package txh_pkg;

  // Bus response as seen by the halt logic.
  typedef struct packed {
    logic vld;
    logic addr_err;
    logic ecc_err;
  } txh_bus_rsp_t;

  // Source of a general error, for readability of the decode.
  typedef enum logic [1:0] {
    TXH_CAUSE_NONE = 2'd0,
    TXH_CAUSE_DESC = 2'd1,
    TXH_CAUSE_BUS  = 2'd2
  } txh_cause_e;

  function automatic logic bus_rsp_is_err(input txh_bus_rsp_t r);
    return r.vld & (r.addr_err | r.ecc_err);
  endfunction

endpackage

// File: rtl/txh_err_detect.sv
module txh_err_detect
  import txh_pkg::*;
#(
  parameter int NUM_RINGS = 4,
  parameter int LEN_W     = 16,
  parameter int RING_W    = 2
) (
  input  logic                 fetch_vld_i,
  input  logic [RING_W-1:0]    fetch_ring_i,
  input  logic                 fetch_empty_i,
  input  logic                 fetch_ready_i,
  input  logic [LEN_W-1:0]     fetch_len_i,
  input  txh_bus_rsp_t         rsp_i,
  output logic                 gen_err_o,
  output txh_cause_e           cause_o,
  output logic [NUM_RINGS-1:0] set_o
);

  logic desc_err;
  logic bus_err;
  logic [NUM_RINGS-1:0] empty_hit;

  // A descriptor marked ready with zero length is a programming error.
  // An empty fetch takes precedence: its ready flag and length mean nothing.
  always_comb begin
    desc_err = fetch_vld_i & ~fetch_empty_i & fetch_ready_i & (fetch_len_i == '0);
    bus_err  = bus_rsp_is_err(rsp_i);
  end

  always_comb begin
    if (bus_err)       cause_o = TXH_CAUSE_BUS;
    else if (desc_err) cause_o = TXH_CAUSE_DESC;
    else               cause_o = TXH_CAUSE_NONE;
  end

  assign gen_err_o = (cause_o != TXH_CAUSE_NONE);

  // Each ring looks for its own index on an empty fetch. An index beyond
  // the last ring matches nothing.
  for (genvar i = 0; i < NUM_RINGS; i++) begin : g_ring
    assign empty_hit[i] = fetch_vld_i & fetch_empty_i & (fetch_ring_i == RING_W'(i));
    assign set_o[i]     = gen_err_o | empty_hit[i];
  end

  // R4: at most one ring is hit by an empty fetch.
  always_comb begin
    a_one_empty_r4: assert ($onehot0(empty_hit));
  end

endmodule

// File: rtl/txh_status_reg.sv
module txh_status_reg #(
  parameter int NUM_RINGS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_RINGS-1:0] set_i,
  input  logic                 wr_en_i,
  input  logic [NUM_RINGS-1:0] wr_data_i,
  output logic [NUM_RINGS-1:0] halt_o
);

  logic [NUM_RINGS-1:0] halt_q;
  logic [NUM_RINGS-1:0] halt_d;
  logic [NUM_RINGS-1:0] clr;
  logic [NUM_RINGS-1:0] bit_en;

  for (genvar i = 0; i < NUM_RINGS; i++) begin : g_bit
    // Next-state logic: setting has priority over a write-one-to-clear.
    always_comb begin
      clr[i]    = wr_en_i & wr_data_i[i];
      bit_en[i] = set_i[i] | clr[i];
      halt_d[i] = set_i[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         halt_q[i] <= 1'b0;
      else if (bit_en[i]) halt_q[i] <= halt_d[i];
    end

    p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_data_i[i] && !set_i[i]) |=> !halt_q[i]);

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i[i] && !(wr_en_i && wr_data_i[i])) |=> (halt_q[i] == $past(halt_q[i])));

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> halt_q[i]);
  end

  // R7: without a set condition no bit can rise.
  p_no_self_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(|set_i) |=> ((halt_q & ~$past(halt_q)) == '0));

  assign halt_o = halt_q;

endmodule

// File: rtl/txh_out_gate.sv
module txh_out_gate #(
  parameter int NUM_RINGS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_RINGS-1:0] q_en_i,
  input  logic                 gstop_i,
  input  logic [NUM_RINGS-1:0] halt_i,
  input  logic                 gen_err_i,
  output logic [NUM_RINGS-1:0] dma_en_o,
  output logic                 any_halted_o,
  output logic                 txe_o
);

  logic txe_q;
  logic txe_d;

  // The event register is loaded every cycle, so its enable is tied high.
  always_comb txe_d = gen_err_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) txe_q <= 1'b0;
    else        txe_q <= txe_d;
  end

  assign txe_o = txe_q;

  for (genvar i = 0; i < NUM_RINGS; i++) begin : g_en
    assign dma_en_o[i] = q_en_i[i] & ~halt_i[i] & ~gstop_i;

    p_halt_blocks_dma_r2: assert property (@(posedge clk) disable iff (!rst_n)
      halt_i[i] |-> !dma_en_o[i]);
  end

  assign any_halted_o = |halt_i;

  p_txe_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    gen_err_i |=> txe_o);

  p_txe_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_err_i |=> !txe_o);

  p_gstop_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    gstop_i |-> (dma_en_o == '0));

endmodule

// File: rtl/tx_ring_halt_ctrl.sv
module tx_ring_halt_ctrl
  import txh_pkg::*;
#(
  parameter int NUM_RINGS = 4,
  parameter int LEN_W     = 16,
  localparam int RING_W   = (NUM_RINGS > 1) ? $clog2(NUM_RINGS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_RINGS-1:0] q_en_i,
  input  logic                 gstop_i,
  input  logic                 fetch_vld_i,
  input  logic [RING_W-1:0]    fetch_ring_i,
  input  logic                 fetch_empty_i,
  input  logic                 fetch_ready_i,
  input  logic [LEN_W-1:0]     fetch_len_i,
  input  logic                 rsp_vld_i,
  input  logic                 rsp_addr_err_i,
  input  logic                 rsp_ecc_err_i,
  input  logic                 wr_en_i,
  input  logic [NUM_RINGS-1:0] wr_data_i,
  output logic [NUM_RINGS-1:0] halt_stat_o,
  output logic [NUM_RINGS-1:0] dma_en_o,
  output logic                 any_halted_o,
  output logic                 txe_o
);

  txh_bus_rsp_t         rsp;
  txh_cause_e           cause;
  logic                 gen_err;
  logic [NUM_RINGS-1:0] set_vec;
  logic [NUM_RINGS-1:0] halt;

  assign rsp = '{vld: rsp_vld_i, addr_err: rsp_addr_err_i, ecc_err: rsp_ecc_err_i};

  txh_err_detect #(
    .NUM_RINGS (NUM_RINGS),
    .LEN_W     (LEN_W),
    .RING_W    (RING_W)
  ) u_detect (
    .fetch_vld_i   (fetch_vld_i),
    .fetch_ring_i  (fetch_ring_i),
    .fetch_empty_i (fetch_empty_i),
    .fetch_ready_i (fetch_ready_i),
    .fetch_len_i   (fetch_len_i),
    .rsp_i         (rsp),
    .gen_err_o     (gen_err),
    .cause_o       (cause),
    .set_o         (set_vec)
  );

  txh_status_reg #(
    .NUM_RINGS (NUM_RINGS)
  ) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (set_vec),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .halt_o    (halt)
  );

  txh_out_gate #(
    .NUM_RINGS (NUM_RINGS)
  ) u_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .q_en_i       (q_en_i),
    .gstop_i      (gstop_i),
    .halt_i       (halt),
    .gen_err_i    (gen_err),
    .dma_en_o     (dma_en_o),
    .any_halted_o (any_halted_o),
    .txe_o        (txe_o)
  );

  assign halt_stat_o = halt;

  // R5/R6: any general error leaves every ring halted.
  p_err_halts_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cause != TXH_CAUSE_NONE) |=> (&halt_stat_o));

  // R6: a flagged bus response is always decoded as an error.
  p_bus_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld_i && (rsp_addr_err_i || rsp_ecc_err_i)) |-> (cause == TXH_CAUSE_BUS));

endmodule

// File: tb/tx_ring_halt_ctrl_tb_top.sv
`timescale 1ns/1ps
module tx_ring_halt_ctrl_tb_top;

  localparam int N  = 3;
  localparam int LW = 4;
  localparam int RW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  q_en;
  logic          gstop;
  logic          fetch_vld;
  logic [RW-1:0] fetch_ring;
  logic          fetch_empty;
  logic          fetch_ready;
  logic [LW-1:0] fetch_len;
  logic          rsp_vld, rsp_addr_err, rsp_ecc_err;
  logic          wr_en;
  logic [N-1:0]  wr_data;
  logic [N-1:0]  halt_stat, dma_en;
  logic          any_halted, txe;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  tx_ring_halt_ctrl #(.NUM_RINGS(N), .LEN_W(LW)) dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .q_en_i         (q_en),
    .gstop_i        (gstop),
    .fetch_vld_i    (fetch_vld),
    .fetch_ring_i   (fetch_ring),
    .fetch_empty_i  (fetch_empty),
    .fetch_ready_i  (fetch_ready),
    .fetch_len_i    (fetch_len),
    .rsp_vld_i      (rsp_vld),
    .rsp_addr_err_i (rsp_addr_err),
    .rsp_ecc_err_i  (rsp_ecc_err),
    .wr_en_i        (wr_en),
    .wr_data_i      (wr_data),
    .halt_stat_o    (halt_stat),
    .dma_en_o       (dma_en),
    .any_halted_o   (any_halted),
    .txe_o          (txe)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    gstop = 0; fetch_vld = 0; fetch_ring = 0; fetch_empty = 0;
    fetch_ready = 0; fetch_len = 0; rsp_vld = 0; rsp_addr_err = 0;
    rsp_ecc_err = 0; wr_en = 0; wr_data = 0;
  endtask

  // Inputs are set up after a falling edge; one rising edge samples them;
  // the next falling edge returns the inputs to idle and outputs are read.
  task automatic step();
    @(negedge clk);
    idle();
    #1;
  endtask

  task automatic set_all();
    rsp_vld = 1; rsp_addr_err = 1;
    step();
  endtask

  task automatic clear_all();
    wr_en = 1; wr_data = '1;
    step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    idle();
    q_en  = '1;
    rst_n = 0;
    repeat (3) @(negedge clk);
    #1;
    check("R1 halt in reset", halt_stat, 0);
    check("R1 txe in reset", txe, 0);
    // R1/R2: DMA enable follows queue enable after reset.
    for (int p = 0; p < 8; p++) begin
      q_en = N'(p); #1;
      check("R1 dma_en=q_en in reset", dma_en, p);
    end
    @(negedge clk);
    rst_n = 1;
    q_en  = '1;
    step();
    check("R1 halt after reset", halt_stat, 0);
    check("R1 any_halted after reset", any_halted, 0);

    // R4: empty fetch halts only its own ring; R2 gating per ring.
    for (int r = 0; r < N; r++) begin
      fetch_vld = 1; fetch_empty = 1; fetch_ring = RW'(r);
      fetch_ready = 1; fetch_len = 0;
      step();
      check("R4 empty halts one ring", halt_stat, 1 << r);
      check("R4 empty raises no txe", txe, 0);
      check("R2 any_halted", any_halted, 1);
      for (int p = 0; p < 8; p++) begin
        q_en = N'(p); #1;
        check("R2 dma_en gating", dma_en, p & ~(1 << r) & 7);
      end
      q_en = '1;
      wr_en = 1; wr_data = N'(1 << r);
      step();
      check("R3 clear of single ring", halt_stat, 0);
    end

    // R3: every clear mask against a fully halted state.
    for (int m = 0; m < 8; m++) begin
      set_all();
      check("R3 all set before clear", halt_stat, 7);
      wr_en = 1; wr_data = N'(m);
      step();
      check("R3 w1c mask", halt_stat, 7 & ~m);
      clear_all();
    end
    // R3: write without enable is ignored.
    set_all();
    wr_en = 0; wr_data = '1;
    step();
    check("R3 no clear without wr_en", halt_stat, 7);
    clear_all();

    // R5/R10: every length with ready high and low, any queue enable.
    for (int rd = 0; rd < 2; rd++) begin
      for (int l = 0; l < 16; l++) begin
        q_en = N'(l % 8);
        fetch_vld = 1; fetch_empty = 0; fetch_ready = rd[0];
        fetch_len = LW'(l); fetch_ring = RW'(l % 3);
        step();
        if (rd == 1 && l == 0) begin
          check("R5 zero length halts all", halt_stat, 7);
          check("R8 txe pulse", txe, 1);
          step();
          check("R8 txe single cycle", txe, 0);
          clear_all();
        end else begin
          check("R10 no halt on good fetch", halt_stat, 0);
          check("R10 no txe on good fetch", txe, 0);
        end
      end
    end
    q_en = '1;
    // R5: invalid fetch strobe ignored.
    fetch_vld = 0; fetch_ready = 1; fetch_len = 0;
    step();
    check("R5 no effect without fetch_vld", halt_stat, 0);

    // R6: all bus response combinations.
    for (int c = 0; c < 8; c++) begin
      rsp_vld = c[0]; rsp_addr_err = c[1]; rsp_ecc_err = c[2];
      step();
      if (c[0] && (c[1] || c[2])) begin
        check("R6 bus error halts all", halt_stat, 7);
        check("R8 txe after bus error", txe, 1);
        clear_all();
      end else begin
        check("R6 no halt without error", halt_stat, 0);
        check("R8 no txe", txe, 0);
      end
    end

    // R8: back-to-back errors keep txe high each following cycle.
    rsp_vld = 1; rsp_ecc_err = 1;
    @(negedge clk);
    rsp_vld = 1; rsp_ecc_err = 1; #1;
    check("R8 txe first of two", txe, 1);
    step();
    check("R8 txe second of two", txe, 1);
    step();
    check("R8 txe drops", txe, 0);
    clear_all();

    // R7: graceful stop never halts, only gates DMA.
    gstop = 1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); gstop = 1; #1;
      check("R7 gstop sets no halt", halt_stat, 0);
      check("R2 gstop gates dma", dma_en, 0);
    end
    step();
    check("R2 dma back after gstop", dma_en, 7);

    // R9: error and clear in the same cycle, error wins.
    set_all();
    rsp_vld = 1; rsp_addr_err = 1; wr_en = 1; wr_data = '1;
    step();
    check("R9 error beats clear", halt_stat, 7);
    clear_all();
    for (int r = 0; r < N; r++) begin
      fetch_vld = 1; fetch_empty = 1; fetch_ring = RW'(r);
      wr_en = 1; wr_data = '1;
      step();
      check("R9 empty beats clear", halt_stat, 1 << r);
      clear_all();
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule